// File: doc/BRIEF.md
# Seven-Segment Display Decoder with Zero Suppression Chain

This block turns a row of 4-bit BCD digits into seven-segment drive patterns for a multi-digit display. Each digit position has its own decoder. Three display-wide controls act on every position: a blanking control that turns every segment off, a lamp test that lights every segment, and a suppression input at the most significant end. The block passes a "this digit was a suppressed zero" flag from each digit position to the next, from the most significant digit down. This lets leading zeros disappear, while the least significant digit always shows its value.

A parameter picks the output polarity. Active-low outputs suit common-anode displays and active-high outputs suit common-cathode displays. The decoded patterns, and the ripple-blank flag leaving the lowest digit that takes part in suppression, are registered on the clock. A synchronous active-high reset clears them, so every output changes one clock after its inputs change.

Top module: `sevseg_chain`

## Requirements
- R1: With all overrides inactive and no suppression, a digit code 0..9 lights segments a..g, with bit 0 = a through bit 6 = g in active-high terms. The patterns are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07, 8:7F, 9:6F (hex).
- R2: Digit codes 10..15 light no segment.
- R3: With ACTIVE_LOW=1 each segment output is the inverse of the active-high pattern (0 = lit). With ACTIVE_LOW=0 it equals the active-high pattern.
- R4: While blank_n is 0, every segment of every digit is off, whatever the digits, lamp_test_n and rbi_n are.
- R5: While lamp_test_n is 0 and blank_n is 1, every segment of every digit is lit, including digits that would otherwise be suppressed.
- R6: A digit other than the least significant one is suppressed (all segments off) exactly when three conditions hold: its ripple input is 0, its code is 0, and lamp_test_n is 1. Its ripple output is then 0. In every other case its ripple output is 1.
- R7: Digit k sits at digits_i[4k+3:4k], and digit 0 is the least significant. rbi_n feeds the most significant digit, and each digit's ripple output feeds the next lower digit. Digit 0 is never suppressed. rbo_n_o carries the ripple output of digit 1.
- R8: All outputs are registered. A value applied before a rising clock edge appears after that edge. In the cycle after reset, every segment is off and rbo_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digits_i | input | 4*NUM_DIGITS | BCD digits, digit 0 in the low nibble |
| lamp_test_n | input | 1 | Lamp test, active low |
| blank_n | input | 1 | Display blanking, active low |
| rbi_n | input | 1 | Ripple-blank input to the most significant digit, 0 enables suppression |
| seg_o | output | 7*NUM_DIGITS | Segment drives, digit k at bits 7k+6:7k, a at the low bit |
| rbo_n_o | output | 1 | Registered ripple-blank output of digit 1 |

## Verification
The bench builds two instances with NUM_DIGITS=4 that receive the same stimulus, one with ACTIVE_LOW=1 and one with ACTIVE_LOW=0. Any inversion error therefore appears as a mismatch against one common expected pattern. Four digits give a chain of three suppressing positions above a fixed least significant digit. This covers values where the zero run stops at each position (0007, 0100, 0010, 1000), the all-zero case in which only the last digit shows, and a zero below a non-zero digit that must stay visible.

// File: rtl/sevseg_pkg.sv
package sevseg_pkg;
  localparam int unsigned BCD_W = 4;
  localparam int unsigned SEG_W = 7;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [BCD_W-1:0] bcd_t;

  localparam seg_t SEG_NONE = '0;
  localparam seg_t SEG_ALL  = '1;
endpackage

// File: rtl/sevseg_glyph.sv
module sevseg_glyph
  import sevseg_pkg::*;
(
  input  bcd_t code_i,
  output seg_t glyph_o
);
  // bit 0 = segment a ... bit 6 = segment g, active high
  always_comb begin
    unique case (code_i)
      4'd0:    glyph_o = 7'h3F;
      4'd1:    glyph_o = 7'h06;
      4'd2:    glyph_o = 7'h5B;
      4'd3:    glyph_o = 7'h4F;
      4'd4:    glyph_o = 7'h66;
      4'd5:    glyph_o = 7'h6D;
      4'd6:    glyph_o = 7'h7D;
      4'd7:    glyph_o = 7'h07;
      4'd8:    glyph_o = 7'h7F;
      4'd9:    glyph_o = 7'h6F;
      default: glyph_o = SEG_NONE;
    endcase
  end
endmodule

// File: rtl/sevseg_ripple.sv
module sevseg_ripple
  import sevseg_pkg::*;
(
  input  bcd_t code_i,
  input  logic lamp_test_n,
  input  logic rbi_n,
  output logic rbo_n
);
  logic is_zero;

  assign is_zero = (code_i == '0);
  // low only for a zero reached by an active suppression request with no lamp test
  assign rbo_n   = ~(~rbi_n & lamp_test_n & is_zero);
endmodule

// File: rtl/sevseg_cell.sv
module sevseg_cell
  import sevseg_pkg::*;
(
  input  bcd_t code_i,
  input  logic lamp_test_n,
  input  logic blank_n,
  input  logic suppress_i,
  output seg_t seg_o
);
  seg_t glyph;

  sevseg_glyph u_glyph (
    .code_i  (code_i),
    .glyph_o (glyph)
  );

  // priority: blanking, lamp test, ripple suppression, decode
  always_comb begin
    if (!blank_n)          seg_o = SEG_NONE;
    else if (!lamp_test_n) seg_o = SEG_ALL;
    else if (suppress_i)   seg_o = SEG_NONE;
    else                   seg_o = glyph;
  end
endmodule

// File: rtl/sevseg_chain.sv
module sevseg_chain
  import sevseg_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
  input  logic                        lamp_test_n,
  input  logic                        blank_n,
  input  logic                        rbi_n,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_o,
  output logic                        rbo_n_o
);
  localparam int unsigned SEGS_TOTAL = NUM_DIGITS * SEG_W;
  localparam logic [SEGS_TOTAL-1:0] OFF_LEVEL = ACTIVE_LOW ? '1 : '0;
  localparam logic [SEGS_TOTAL-1:0] ON_LEVEL  = ACTIVE_LOW ? '0 : '1;

  // rb_n[k] is the ripple output of digit k; rb_n[NUM_DIGITS] is the chain input
  logic [NUM_DIGITS:1]         rb_n;
  logic [SEGS_TOTAL-1:0]       seg_hi;
  logic [SEGS_TOTAL-1:0]       seg_drv;

  assign rb_n[NUM_DIGITS] = rbi_n;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    logic supp;
    if (k > 0) begin : g_chain
      sevseg_ripple u_ripple (
        .code_i      (digits_i[k*BCD_W +: BCD_W]),
        .lamp_test_n (lamp_test_n),
        .rbi_n       (rb_n[k+1]),
        .rbo_n       (rb_n[k])
      );
      assign supp = ~rb_n[k];
    end else begin : g_lsd
      assign supp = 1'b0;
    end

    sevseg_cell u_cell (
      .code_i      (digits_i[k*BCD_W +: BCD_W]),
      .lamp_test_n (lamp_test_n),
      .blank_n     (blank_n),
      .suppress_i  (supp),
      .seg_o       (seg_hi[k*SEG_W +: SEG_W])
    );
  end

  if (ACTIVE_LOW) begin : g_pol_low
    assign seg_drv = ~seg_hi;
  end else begin : g_pol_high
    assign seg_drv = seg_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_o   <= OFF_LEVEL;
      rbo_n_o <= 1'b1;
    end else begin
      seg_o   <= seg_drv;
      rbo_n_o <= rb_n[1];
    end
  end

  // ---------------- assertions ----------------
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R4
  blank_off_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(blank_n)) |-> (seg_o == OFF_LEVEL));

  // R5
  lamp_on_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(blank_n) && !$past(lamp_test_n)) |-> (seg_o == ON_LEVEL));

  // R6
  rbo_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rbi_n)) |-> rbo_n_o);

  // R6
  rbo_lamp_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(lamp_test_n)) |-> rbo_n_o);

  // R7
  lsd_shown_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(blank_n) && $past(lamp_test_n) && ($past(digits_i[BCD_W-1:0]) < 4'd10))
      |-> (seg_o[SEG_W-1:0] != OFF_LEVEL[SEG_W-1:0]));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (seg_o == OFF_LEVEL && rbo_n_o));
endmodule

// File: tb/sevseg_chain_test.sv
module sevseg_chain_test;
  localparam int ND = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [ND*4-1:0] digits = '0;
  logic            lamp_n = 1'b1;
  logic            blank_n = 1'b1;
  logic            rbi_n = 1'b1;
  logic [ND*7-1:0] seg_lo, seg_hi;
  logic            rbo_lo, rbo_hi;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sevseg_chain #(.NUM_DIGITS(ND), .ACTIVE_LOW(1'b1)) uut (
    .clk(clk), .rst(rst), .digits_i(digits), .lamp_test_n(lamp_n),
    .blank_n(blank_n), .rbi_n(rbi_n), .seg_o(seg_lo), .rbo_n_o(rbo_lo));

  sevseg_chain #(.NUM_DIGITS(ND), .ACTIVE_LOW(1'b0)) uut_hi (
    .clk(clk), .rst(rst), .digits_i(digits), .lamp_test_n(lamp_n),
    .blank_n(blank_n), .rbi_n(rbi_n), .seg_o(seg_hi), .rbo_n_o(rbo_hi));

  function automatic logic [6:0] ref_glyph(input int v);
    case (v)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // behavioural reference: walk from the most significant digit down
  task automatic model(output logic [ND*7-1:0] segs, output logic rbo);
    bit zero_run;
    zero_run = (rbi_n == 1'b0);
    rbo = 1'b1;
    for (int d = ND - 1; d >= 0; d--) begin
      int v;
      v = int'(digits[d*4 +: 4]);
      if (d > 0) zero_run = zero_run && lamp_n && (v == 0);
      else zero_run = 1'b0;
      if (!blank_n)      segs[d*7 +: 7] = 7'h00;
      else if (!lamp_n)  segs[d*7 +: 7] = 7'h7F;
      else if (zero_run) segs[d*7 +: 7] = 7'h00;
      else               segs[d*7 +: 7] = ref_glyph(v);
      if (d == 1) rbo = !zero_run;
    end
  endtask

  task automatic check(input string req, input logic [ND*7-1:0] got,
                       input logic [ND*7-1:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s digits=%h actual=%h expected=%h", req, what, digits, got, exp);
    end
  endtask

  // inputs set at a falling edge; result sampled at the next falling edge
  task automatic apply(input string req, input logic [15:0] dg, input logic lt,
                       input logic bl, input logic rb);
    logic [ND*7-1:0] e;
    logic            r;
    digits = dg; lamp_n = lt; blank_n = bl; rbi_n = rb;
    model(e, r);
    @(negedge clk);
    check(req, seg_hi, e, "active-high segments");
    check({req, "/R3"}, seg_lo, ~e, "active-low segments");
    check({req, "/R6"}, {27'd0, rbo_lo}, {27'd0, r}, "ripple out");
    check({req, "/R3"}, {27'd0, rbo_hi}, {27'd0, r}, "ripple out hi instance");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", seg_lo, '1, "reset active-low");
    check("R8", seg_hi, '0, "reset active-high");
    check("R8", {27'd0, rbo_lo}, 28'd1, "reset ripple out");
    rst = 1'b0;

    // R1 / R2: every code in every position, no suppression
    for (int v = 0; v < 16; v++) begin
      logic [3:0] c;
      c = v[3:0];
      apply(v < 10 ? "R1" : "R2", {c, c, c, c}, 1'b1, 1'b1, 1'b1);
    end
    apply("R1", 16'h1234, 1'b1, 1'b1, 1'b1);
    apply("R1", 16'h5678, 1'b1, 1'b1, 1'b1);
    apply("R2", 16'hA9F0, 1'b1, 1'b1, 1'b1);

    // R6 / R7: chain suppression with rbi_n low
    apply("R7", 16'h0007, 1'b1, 1'b1, 1'b0);
    apply("R7", 16'h0100, 1'b1, 1'b1, 1'b0);
    apply("R7", 16'h0010, 1'b1, 1'b1, 1'b0);
    apply("R7", 16'h1000, 1'b1, 1'b1, 1'b0);
    apply("R7", 16'h0000, 1'b1, 1'b1, 1'b0);
    apply("R6", 16'h00A0, 1'b1, 1'b1, 1'b0);
    apply("R6", 16'h0007, 1'b1, 1'b1, 1'b1);
    apply("R6", 16'h0000, 1'b1, 1'b1, 1'b1);

    // R5: lamp test overrides suppression
    apply("R5", 16'h0000, 1'b0, 1'b1, 1'b0);
    apply("R5", 16'hF3C1, 1'b0, 1'b1, 1'b1);

    // R4: blanking overrides everything
    apply("R4", 16'h0000, 1'b0, 1'b0, 1'b0);
    apply("R4", 16'h9876, 1'b1, 1'b0, 1'b1);
    apply("R4", 16'h0005, 1'b1, 1'b0, 1'b0);

    // R8: value only appears after the edge; reset clears it again
    apply("R8", 16'h0808, 1'b1, 1'b1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R8", seg_hi, '0, "re-reset active-high");
    check("R8", seg_lo, '1, "re-reset active-low");
    rst = 1'b0;
    apply("R8", 16'h0042, 1'b1, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=%0d expected<=20000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule